// File: doc/BRIEF.md
# Dual-Source Output Buffer Interrupt Arbiter

This block sits between two byte-producing input channels, a keyboard channel and an auxiliary pointing-device channel, and the host-facing side of a keyboard controller. Each channel raises a level while it has a byte waiting. The block records both levels in a small pending register. From that register it derives the shared "output buffer full" flag, the "auxiliary buffer full" flag, the matching output-port bits, and two interrupt levels that are gated by the controller's mode byte.

When both channels hold data, the keyboard channel is always served first. A read of the data port takes the byte from the channel the arbiter currently favours. It also returns a one-cycle acknowledge to that channel only, so that the channel can pop its byte. The channel FIFOs and the command decoder that writes the mode byte live outside this block.

Top module: `obuf_irq_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, every output is low and the read byte is zero.
- R2: One clock after the channel levels are sampled, the buffer-full status bit and output-port bit 4 are both 1 if either level was high, and both are 0 if neither was high.
- R3: The auxiliary-full status bit and output-port bit 5 are 1 only when the auxiliary level alone was high. If both levels were high they are 0, because keyboard data has priority.
- R4: The keyboard interrupt is high exactly when buffer-full is set, auxiliary-full is clear, mode bit 0 (keyboard interrupt enable) is 1 and mode bit 4 (keyboard interface off) is 0.
- R5: The mouse interrupt is high exactly when buffer-full and auxiliary-full are both set and mode bit 1 (auxiliary interrupt enable) is 1. Mode bit 5 (auxiliary interface off) has no effect on it.
- R6: A data-port read strobe returns, one clock later, the auxiliary byte if the auxiliary flag alone was pending, and the keyboard byte in every other case, including when nothing is pending.
- R7: Each read strobe gives a one-cycle acknowledge, one clock later, to the channel whose byte was returned. The other channel gets no acknowledge.
- R8: Both interrupt levels are registered. A change of the mode byte or of either channel level shows on them exactly one clock later.
- R9: With nothing pending, both interrupts are low whatever the mode byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_avail_i | input | 1 | Keyboard channel has a byte waiting |
| aux_avail_i | input | 1 | Auxiliary channel has a byte waiting |
| mode_i | input | 8 | Controller mode byte |
| kbd_byte_i | input | 8 | Head byte of the keyboard channel |
| aux_byte_i | input | 8 | Head byte of the auxiliary channel |
| data_rd_i | input | 1 | Data-port read strobe |
| stat_full_o | output | 1 | Status bit 0: buffer full |
| stat_aux_full_o | output | 1 | Status bit 5: buffer holds auxiliary data |
| oport_full_o | output | 1 | Output-port bit 4 |
| oport_aux_full_o | output | 1 | Output-port bit 5 |
| kbd_irq_o | output | 1 | Keyboard interrupt level |
| aux_irq_o | output | 1 | Mouse interrupt level |
| rd_byte_o | output | 8 | Byte returned by the last data-port read |
| kbd_ack_o | output | 1 | Pop pulse to the keyboard channel |
| aux_ack_o | output | 1 | Pop pulse to the auxiliary channel |

## Verification
The pending pair is driven through all four combinations: neither, keyboard only, auxiliary only and both. These show whether the any-pending flag and the keyboard-first priority are told apart correctly, and the both-pending case in particular exposes a design that lets auxiliary data win. For each interrupt, the mode byte is stepped through its enable bit and its interface-off bit, both alone and together. This separates the keyboard gate, which honours the interface-off bit, from the mouse gate, which ignores its own. Reads are issued under each pending pattern, with distinct bytes on the two channels, so that the returned byte and the acknowledge target show which channel was selected.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
    // Mode byte bit positions decoded by the interrupt gates
    localparam int unsigned MODE_KBD_IE  = 0;
    localparam int unsigned MODE_AUX_IE  = 1;
    localparam int unsigned MODE_KBD_OFF = 4;
    localparam int unsigned MODE_AUX_OFF = 5;

    // Pending flag positions
    localparam int unsigned PEND_KBD = 0;
    localparam int unsigned PEND_AUX = 1;
    localparam int unsigned NUM_SRC  = 2;

    typedef enum logic {
        SRC_KBD = 1'b0,
        SRC_AUX = 1'b1
    } src_e;
endpackage

// File: rtl/obuf_src_select.sv
module obuf_src_select
    import obuf_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic               aux_only_o,
    output src_e               src_o
);
    always_comb begin
        any_o      = |pend_i;
        aux_only_o = pend_i[PEND_AUX] && !pend_i[PEND_KBD];
        src_o      = aux_only_o ? SRC_AUX : SRC_KBD;
    end
endmodule

// File: rtl/obuf_irq_gate.sv
module obuf_irq_gate
    import obuf_arb_pkg::*;
#(
    parameter int unsigned MODE_W = 8
) (
    input  logic              any_i,
    input  logic              aux_only_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              kbd_irq_o,
    output logic              aux_irq_o
);
    always_comb begin
        kbd_irq_o = any_i && !aux_only_i && mode_i[MODE_KBD_IE] && !mode_i[MODE_KBD_OFF];
        aux_irq_o = any_i &&  aux_only_i && mode_i[MODE_AUX_IE];
    end
endmodule

// File: rtl/obuf_irq_arbiter.sv
module obuf_irq_arbiter
    import obuf_arb_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kbd_avail_i,
    input  logic              aux_avail_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DATA_W-1:0] kbd_byte_i,
    input  logic [DATA_W-1:0] aux_byte_i,
    input  logic              data_rd_i,
    output logic              stat_full_o,
    output logic              stat_aux_full_o,
    output logic              oport_full_o,
    output logic              oport_aux_full_o,
    output logic              kbd_irq_o,
    output logic              aux_irq_o,
    output logic [DATA_W-1:0] rd_byte_o,
    output logic              kbd_ack_o,
    output logic              aux_ack_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic               kirq;
        logic               airq;
        logic [DATA_W-1:0]  rbyte;
        logic [NUM_SRC-1:0] ack;
    } arb_state_t;

    arb_state_t st_d, st_q;

    // Selection seen by the host in the current cycle
    logic cur_any, cur_aux_only;
    src_e cur_src;
    obuf_src_select u_sel_cur (
        .pend_i     (st_q.pend),
        .any_o      (cur_any),
        .aux_only_o (cur_aux_only),
        .src_o      (cur_src)
    );

    // Selection for the pending value about to be registered
    logic [NUM_SRC-1:0] pend_next;
    logic nxt_any, nxt_aux_only;
    src_e nxt_src;
    always_comb begin
        pend_next           = '0;
        pend_next[PEND_KBD] = kbd_avail_i;
        pend_next[PEND_AUX] = aux_avail_i;
    end
    obuf_src_select u_sel_nxt (
        .pend_i     (pend_next),
        .any_o      (nxt_any),
        .aux_only_o (nxt_aux_only),
        .src_o      (nxt_src)
    );

    logic kirq_nxt, airq_nxt;
    obuf_irq_gate #(.MODE_W(MODE_W)) u_gate (
        .any_i      (nxt_any),
        .aux_only_i (nxt_aux_only),
        .mode_i     (mode_i),
        .kbd_irq_o  (kirq_nxt),
        .aux_irq_o  (airq_nxt)
    );

    // Acknowledge routing, one lane per source
    logic [NUM_SRC-1:0] ack_nxt;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
        localparam src_e LANE_SRC = (g == PEND_AUX) ? SRC_AUX : SRC_KBD;
        assign ack_nxt[g] = data_rd_i && (cur_src == LANE_SRC);
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_next;
        st_d.kirq = kirq_nxt;
        st_d.airq = airq_nxt;
        st_d.ack  = ack_nxt;
        if (data_rd_i) begin
            st_d.rbyte = (cur_src == SRC_AUX) ? aux_byte_i : kbd_byte_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_full_o      = cur_any;
    assign stat_aux_full_o  = cur_aux_only;
    assign oport_full_o     = cur_any;
    assign oport_aux_full_o = cur_aux_only;
    assign kbd_irq_o        = st_q.kirq;
    assign aux_irq_o        = st_q.airq;
    assign rd_byte_o        = st_q.rbyte;
    assign kbd_ack_o        = st_q.ack[PEND_KBD];
    assign aux_ack_o        = st_q.ack[PEND_AUX];
endmodule

// File: rtl/obuf_irq_arbiter_chk.sv
module obuf_irq_arbiter_chk #(
    parameter int unsigned MODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kbd_avail_i,
    input logic              aux_avail_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              data_rd_i,
    input logic              stat_full_o,
    input logic              stat_aux_full_o,
    input logic              oport_full_o,
    input logic              oport_aux_full_o,
    input logic              kbd_irq_o,
    input logic              aux_irq_o,
    input logic              kbd_ack_o,
    input logic              aux_ack_o
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_full_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (stat_full_o == ($past(kbd_avail_i) || $past(aux_avail_i))));

    assert_oport_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oport_full_o == stat_full_o);

    assert_aux_sole_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (stat_aux_full_o == ($past(aux_avail_i) && !$past(kbd_avail_i))));

    assert_kirq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (kbd_irq_o == (stat_full_o && !stat_aux_full_o &&
                                  $past(mode_i[0]) && !$past(mode_i[4]))));

    assert_airq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (aux_irq_o == (stat_full_o && stat_aux_full_o && $past(mode_i[1]))));

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({kbd_ack_o, aux_ack_o}) <= 1);

    assert_ack_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_ack_o || aux_ack_o) |-> (seen_q && $past(data_rd_i)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_full_o |-> (!kbd_irq_o && !aux_irq_o));
endmodule

bind obuf_irq_arbiter obuf_irq_arbiter_chk #(.MODE_W(MODE_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .kbd_avail_i      (kbd_avail_i),
    .aux_avail_i      (aux_avail_i),
    .mode_i           (mode_i),
    .data_rd_i        (data_rd_i),
    .stat_full_o      (stat_full_o),
    .stat_aux_full_o  (stat_aux_full_o),
    .oport_full_o     (oport_full_o),
    .oport_aux_full_o (oport_aux_full_o),
    .kbd_irq_o        (kbd_irq_o),
    .aux_irq_o        (aux_irq_o),
    .kbd_ack_o        (kbd_ack_o),
    .aux_ack_o        (aux_ack_o)
);

// File: tb/test_obuf_irq_arbiter.sv
module test_obuf_irq_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kbd_avail_i = 1'b0;
    logic       aux_avail_i = 1'b0;
    logic [7:0] mode_i = 8'h00;
    logic [7:0] kbd_byte_i = 8'hA5;
    logic [7:0] aux_byte_i = 8'h3C;
    logic       data_rd_i = 1'b0;
    logic       stat_full_o, stat_aux_full_o, oport_full_o, oport_aux_full_o;
    logic       kbd_irq_o, aux_irq_o, kbd_ack_o, aux_ack_o;
    logic [7:0] rd_byte_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    obuf_irq_arbiter i_obuf_irq_arbiter (
        .clk              (clk),
        .rst_n            (rst_n),
        .kbd_avail_i      (kbd_avail_i),
        .aux_avail_i      (aux_avail_i),
        .mode_i           (mode_i),
        .kbd_byte_i       (kbd_byte_i),
        .aux_byte_i       (aux_byte_i),
        .data_rd_i        (data_rd_i),
        .stat_full_o      (stat_full_o),
        .stat_aux_full_o  (stat_aux_full_o),
        .oport_full_o     (oport_full_o),
        .oport_aux_full_o (oport_aux_full_o),
        .kbd_irq_o        (kbd_irq_o),
        .aux_irq_o        (aux_irq_o),
        .rd_byte_o        (rd_byte_o),
        .kbd_ack_o        (kbd_ack_o),
        .aux_ack_o        (aux_ack_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply levels and mode at a falling edge, sample one full cycle later
    task automatic apply(input logic k, input logic a, input logic [7:0] m);
        kbd_avail_i = k;
        aux_avail_i = a;
        mode_i      = m;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 full",  {7'd0, stat_full_o}, 8'h00);
        chk("R1 auxfull", {7'd0, stat_aux_full_o}, 8'h00);
        chk("R1 irqs",  {6'd0, kbd_irq_o, aux_irq_o}, 8'h00);
        chk("R1 byte",  rd_byte_o, 8'h00);
        chk("R1 acks",  {6'd0, kbd_ack_o, aux_ack_o}, 8'h00);
    endtask

    task automatic t_pending_patterns();
        for (int p = 0; p < 4; p++) begin
            logic k, a, any_e, sole_e;
            k = p[0]; a = p[1];
            any_e  = k | a;
            sole_e = a & ~k;
            apply(k, a, 8'h03);
            chk($sformatf("R2 full p=%0d", p), {7'd0, stat_full_o}, {7'd0, any_e});
            chk($sformatf("R2 oport4 p=%0d", p), {7'd0, oport_full_o}, {7'd0, any_e});
            chk($sformatf("R3 auxfull p=%0d", p), {7'd0, stat_aux_full_o}, {7'd0, sole_e});
            chk($sformatf("R3 oport5 p=%0d", p), {7'd0, oport_aux_full_o}, {7'd0, sole_e});
            chk($sformatf("R4 kirq p=%0d", p), {7'd0, kbd_irq_o}, {7'd0, any_e & ~sole_e});
            chk($sformatf("R5 airq p=%0d", p), {7'd0, aux_irq_o}, {7'd0, sole_e});
        end
    endtask

    task automatic t_kbd_gate();
        apply(1'b1, 1'b0, 8'h00); chk("R4 ie off", {7'd0, kbd_irq_o}, 8'h00);
        apply(1'b1, 1'b0, 8'h01); chk("R4 ie on",  {7'd0, kbd_irq_o}, 8'h01);
        apply(1'b1, 1'b0, 8'h11); chk("R4 iface off", {7'd0, kbd_irq_o}, 8'h00);
        apply(1'b1, 1'b0, 8'h21); chk("R4 auxoff no effect", {7'd0, kbd_irq_o}, 8'h01);
    endtask

    task automatic t_aux_gate();
        apply(1'b0, 1'b1, 8'h00); chk("R5 ie off", {7'd0, aux_irq_o}, 8'h00);
        apply(1'b0, 1'b1, 8'h02); chk("R5 ie on",  {7'd0, aux_irq_o}, 8'h01);
        apply(1'b0, 1'b1, 8'h22); chk("R5 auxoff ignored", {7'd0, aux_irq_o}, 8'h01);
        apply(1'b0, 1'b1, 8'h12); chk("R5 kbdoff ignored", {7'd0, aux_irq_o}, 8'h01);
        chk("R5 no kirq", {7'd0, kbd_irq_o}, 8'h00);
    endtask

    task automatic t_latency();
        apply(1'b1, 1'b0, 8'h01);
        // change mode only, check just before and just after the edge
        mode_i = 8'h00;
        @(posedge clk); #1;
        chk("R8 after edge", {7'd0, kbd_irq_o}, 8'h00);
        @(negedge clk);
        mode_i = 8'h01;
        #2;
        chk("R8 held before edge", {7'd0, kbd_irq_o}, 8'h00);
        @(negedge clk);
        chk("R8 rises one clock later", {7'd0, kbd_irq_o}, 8'h01);
    endtask

    task automatic t_idle();
        apply(1'b0, 1'b0, 8'hFF);
        chk("R9 irqs idle ff", {6'd0, kbd_irq_o, aux_irq_o}, 8'h00);
        apply(1'b0, 1'b0, 8'h03);
        chk("R9 irqs idle 03", {6'd0, kbd_irq_o, aux_irq_o}, 8'h00);
    endtask

    task automatic do_read(input logic k, input logic a, input logic [7:0] exp_b,
                           input logic exp_k, input string tag);
        apply(k, a, 8'h03);
        kbd_byte_i = kbd_byte_i + 8'h01;
        aux_byte_i = aux_byte_i + 8'h01;
        exp_b      = exp_b + 8'h01;
        data_rd_i  = 1'b1;
        @(negedge clk);
        data_rd_i  = 1'b0;
        chk({"R6 byte ", tag}, rd_byte_o, exp_b);
        chk({"R7 ack ", tag}, {6'd0, kbd_ack_o, aux_ack_o}, exp_k ? 8'h02 : 8'h01);
        @(negedge clk);
        chk({"R7 pulse ends ", tag}, {6'd0, kbd_ack_o, aux_ack_o}, 8'h00);
        chk({"R6 byte held ", tag}, rd_byte_o, exp_b);
    endtask

    task automatic t_reads();
        do_read(1'b1, 1'b1, kbd_byte_i, 1'b1, "both");
        do_read(1'b0, 1'b1, aux_byte_i, 1'b0, "aux");
        do_read(1'b1, 1'b0, kbd_byte_i, 1'b1, "kbd");
        do_read(1'b0, 1'b0, kbd_byte_i, 1'b1, "none");
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        kbd_avail_i = 1'b1;
        aux_avail_i = 1'b1;
        mode_i      = 8'hFF;
        repeat (3) @(negedge clk);
        t_reset();
        kbd_avail_i = 1'b0;
        aux_avail_i = 1'b0;
        mode_i      = 8'h00;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pending_patterns();
        t_kbd_gate();
        t_aux_gate();
        t_latency();
        t_idle();
        t_reads();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule